// File: doc/BRIEF.md
# Half-Bridge Shoot-Through Interlock

This block guards one half-bridge leg. It sits between the high-side and low-side ON commands and the two gate drive outputs, and it keeps the two gates from ever being on together. Both commands are active-low. Each command is first brought into the clock domain through its own synchronizer chain. After that, an arbiter gives the leg to whichever side asked first. A conflicting request from the opposite side is not dropped. It waits, and it takes over on the same clock edge that the owning side lets go, provided it is still asserted at that point.

One instance is used per phase. The block inserts no dead time, because the command source upstream is responsible for spacing the two commands. It has no noise filter and no fault or status output.

Top module: `hb_interlock`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `hi_gate` and `lo_gate` are both 0 and neither side owns the leg.
- R2: A command input is ON when it is low (0) and OFF when it is high (1). When the opposite side is idle, a command that goes low shows up as a 1 on its gate at the third rising clock edge after the input changes: two synchronizer stages plus one output register.
- R3: While `hi_gate` is 1 and the high-side request stays active, `lo_gate` stays 0 whatever `lo_cmd_n` does.
- R4: While `lo_gate` is 1 and the low-side request stays active, `hi_gate` stays 0 whatever `hi_cmd_n` does.
- R5: When the owning side's synchronized request goes OFF while the other side's synchronized request is ON, the owner's gate turns off and the other gate turns on at the same clock edge.
- R6: A blocked side whose request goes OFF before the owner releases never turns its gate on.
- R7: When both synchronized requests become ON at the same edge and neither gate is on, the high side wins.
- R8: A gate turns off at the clock edge that registers its own synchronized request going OFF, which is the third rising edge after its input goes high.
- R9: `hi_gate` and `lo_gate` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_cmd_n | input | 1 | High-side ON command, active low, asynchronous |
| lo_cmd_n | input | 1 | Low-side ON command, active low, asynchronous |
| hi_gate | output | 1 | High-side gate drive, registered, active high |
| lo_gate | output | 1 | Low-side gate drive, registered, active high |

## Verification
The case that needs care is when a release and a handover land on the same edge. The owner's request drops out of the synchronizer at the same clock that the waiting side's request is present, so one register update has to switch both gates at once without ever driving them both high. The bench provokes this by holding one command, raising a conflicting one, and then toggling both inputs in the same cycle. It also sweeps every sequence of three input pairs with several hold lengths. After every clock it compares both gates with a reference model computed in the bench, which catches any cycle where the handover comes late, comes early, or overlaps.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'b00,
    OWN_HI   = 2'b01,
    OWN_LO   = 2'b10
  } owner_e;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int STAGES   = 2,
  parameter bit IDLE_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{IDLE_VAL}};
    else        chain_q <= chain_d;
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/hb_arbiter.sv
module hb_arbiter
  import hb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_hi,
  input  logic req_lo,
  output logic hi_gate,
  output logic lo_gate
);
  owner_e cur_own;
  owner_e nxt_own;
  logic   hi_q, lo_q;
  logic   hi_d, lo_d;
  logic   upd_en;

  always_comb begin
    case ({lo_q, hi_q})
      2'b01:   cur_own = OWN_HI;
      2'b10:   cur_own = OWN_LO;
      default: cur_own = OWN_NONE;
    endcase
  end

  always_comb begin
    nxt_own = OWN_NONE;
    case (cur_own)
      OWN_HI: begin
        if (req_hi)      nxt_own = OWN_HI;
        else if (req_lo) nxt_own = OWN_LO;
      end
      OWN_LO: begin
        if (req_lo)      nxt_own = OWN_LO;
        else if (req_hi) nxt_own = OWN_HI;
      end
      default: begin
        if (req_hi)      nxt_own = OWN_HI;
        else if (req_lo) nxt_own = OWN_LO;
      end
    endcase
    hi_d   = (nxt_own == OWN_HI);
    lo_d   = (nxt_own == OWN_LO);
    upd_en = (hi_d != hi_q) || (lo_d != lo_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else if (upd_en) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign hi_gate = hi_q;
  assign lo_gate = lo_q;

  // R9
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hi_gate && lo_gate));
  // R3
  hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_gate && req_hi) |=> (hi_gate && !lo_gate));
  // R4
  lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_gate && req_lo) |=> (lo_gate && !hi_gate));
  // R5
  handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_gate && !req_hi && req_lo) |=> (lo_gate && !hi_gate));
  // R7
  tie_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hi_gate && !lo_gate && req_hi && req_lo) |=> hi_gate);
  // R8
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_gate && !req_lo) |=> !lo_gate);
endmodule

// File: rtl/hb_interlock.sv
module hb_interlock #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_cmd_n,
  input  logic lo_cmd_n,
  output logic hi_gate,
  output logic lo_gate
);
  localparam int NUM_SIDES = 2;

  logic [NUM_SIDES-1:0] cmd_raw_n;
  logic [NUM_SIDES-1:0] cmd_sync_n;
  logic                 req_hi, req_lo;

  assign cmd_raw_n = {lo_cmd_n, hi_cmd_n};

  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    hb_sync #(
      .STAGES   (SYNC_STAGES),
      .IDLE_VAL (1'b1)
    ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (cmd_raw_n[s]),
      .dout (cmd_sync_n[s])
    );
  end

  assign req_hi = ~cmd_sync_n[0];
  assign req_lo = ~cmd_sync_n[1];

  hb_arbiter u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_hi (req_hi),
    .req_lo (req_lo),
    .hi_gate(hi_gate),
    .lo_gate(lo_gate)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (!hi_gate && !lo_gate));
endmodule

// File: tb/hb_interlock_test.sv
module hb_interlock_test;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic hi_cmd_n, lo_cmd_n;
  logic hi_gate, lo_gate;

  int n_run  = 0;
  int n_fail = 0;

  logic m_s1h, m_s1l, m_s2h, m_s2l;
  logic m_hg, m_lg;

  always #(CLK_NS/2) clk = ~clk;

  hb_interlock uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .hi_cmd_n(hi_cmd_n),
    .lo_cmd_n(lo_cmd_n),
    .hi_gate (hi_gate),
    .lo_gate (lo_gate)
  );

  task automatic check(input string tag, input logic eh, input logic el);
    n_run++;
    if (hi_gate !== eh || lo_gate !== el) begin
      n_fail++;
      $display("FAIL %s: gates hi/lo = %b%b expected %b%b", tag, hi_gate, lo_gate, eh, el);
    end
  endtask

  task automatic model_tick;
    logic rh, rl, nh, nl;
    rh = ~m_s2h; rl = ~m_s2l;
    nh = 1'b0; nl = 1'b0;
    if (m_hg) begin
      if (rh) nh = 1'b1; else if (rl) nl = 1'b1;
    end else if (m_lg) begin
      if (rl) nl = 1'b1; else if (rh) nh = 1'b1;
    end else begin
      if (rh) nh = 1'b1; else if (rl) nl = 1'b1;
    end
    m_hg = nh; m_lg = nl;
    m_s2h = m_s1h; m_s2l = m_s1l;
    m_s1h = hi_cmd_n; m_s1l = lo_cmd_n;
  endtask

  task automatic step(input logic h_n, input logic l_n, input string tag);
    hi_cmd_n = h_n;
    lo_cmd_n = l_n;
    @(posedge clk);
    model_tick();
    @(negedge clk);
    check(tag, m_hg, m_lg);
    if (hi_gate && lo_gate) begin
      n_run++; n_fail++;
      $display("FAIL R9: both gates on, actual 11 expected not 11");
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b1, "R8 idle");
  endtask

  initial begin
    #(CLK_NS * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    hi_cmd_n = 1'b0;
    lo_cmd_n = 1'b0;
    m_s1h = 1'b1; m_s1l = 1'b1; m_s2h = 1'b1; m_s2l = 1'b1;
    m_hg = 1'b0; m_lg = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 in reset", 1'b0, 1'b0);
    hi_cmd_n = 1'b1; lo_cmd_n = 1'b1;
    rst_n = 1'b1;
    step(1'b1, 1'b1, "R1 after release");
    idle(2);

    // R2 latency: gate rises on third edge
    step(1'b0, 1'b1, "R2 edge1");
    step(1'b0, 1'b1, "R2 edge2");
    step(1'b0, 1'b1, "R2 edge3");
    check("R2 hi on", 1'b1, 1'b0);
    // R3 low side blocked while high holds
    step(1'b0, 1'b0, "R3 conflict");
    step(1'b0, 1'b1, "R3 noise gone");
    step(1'b0, 1'b0, "R3 conflict again");
    repeat (3) step(1'b0, 1'b0, "R3 held");
    check("R3 lo blocked", 1'b1, 1'b0);
    // R5 handover: release high with low pending
    step(1'b1, 1'b0, "R5 release");
    step(1'b1, 1'b0, "R5 wait");
    step(1'b1, 1'b0, "R5 handover edge");
    check("R5 lo took over", 1'b0, 1'b1);
    // R4 high blocked while low holds
    repeat (4) step(1'b0, 1'b0, "R4 conflict");
    check("R4 hi blocked", 1'b0, 1'b1);
    // R8 release off latency
    step(1'b1, 1'b1, "R8 rel1");
    step(1'b1, 1'b1, "R8 rel2");
    check("R8 still on", 1'b0, 1'b1);
    step(1'b1, 1'b1, "R8 rel3");
    check("R8 off", 1'b0, 1'b0);
    idle(2);
    // R6 blocked request withdrawn before release
    repeat (4) step(1'b0, 1'b1, "R6 hi own");
    repeat (3) step(1'b0, 1'b0, "R6 lo blocked");
    repeat (3) step(1'b0, 1'b1, "R6 lo withdrawn");
    repeat (5) step(1'b1, 1'b1, "R6 hi release");
    check("R6 lo never on", 1'b0, 1'b0);
    // R7 simultaneous arrival
    repeat (3) step(1'b0, 1'b0, "R7 tie");
    check("R7 hi wins", 1'b1, 1'b0);
    // same-cycle swap of both inputs
    repeat (3) step(1'b1, 1'b0, "R5 swap");
    check("R5 swap lo", 1'b0, 1'b1);
    idle(4);

    // near-exhaustive sweep over three-phase input sequences
    for (int d = 1; d <= 3; d++)
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++)
          for (int c = 0; c < 4; c++) begin
            for (int k = 0; k < d; k++) step(a[1], a[0], "R9 sweep");
            for (int k = 0; k < d; k++) step(b[1], b[0], "R9 sweep");
            for (int k = 0; k < d; k++) step(c[1], c[0], "R9 sweep");
            idle(3);
          end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule